// File: doc/BRIEF.md
# Configurable CRC Channel with Standard Presets

This block is a single CRC calculation channel controlled through a small synchronous register bus. Software sets the generator polynomial, the CRC width, the starting value, the final XOR mask and three ordering options: reverse the bits of each input byte, reverse the bits of the finished CRC, and reverse the byte order of each input word. Each option can be written on its own. Writing a code to the preset register loads the complete set of values for one of fifteen common CRC standards in a single write.

Each 32-bit word written to the data register is folded into the running CRC in a single clock. The data path is a fully unrolled serial LFSR that takes the word most significant bit first. The result register returns the finished CRC on the next cycle: the state is masked to the width, reflected if that option is set, and XORed with the output mask. The channel occupies a 64-byte address window. Reads are combinational from the address, and register accesses are word aligned.

Top module: `crc_chan`

## Requirements
- R1: After the synchronous reset every register reads 0, including the result. The width field reads 0, which selects a 32-bit CRC.
- R2: Word offsets within the window: preset code 0x00, clear 0x04, polynomial 0x08, start value 0x0C, output mask 0x10, mode 0x14, data 0x18, result 0x1C. The polynomial, start value, output mask and data registers read back the last 32-bit value written to them. The preset register reads back its 8-bit code. The mode register keeps only width in bits [5:0], input bit reversal in bit 8, output bit reversal in bit 16 and input byte swap in bit 24, so writing 0xFFFFFFFF reads back 0x0101013F.
- R3: Writing a word with bit 0 set to the clear offset returns every setting, the preset code, the data register and the CRC state to their reset values. A write with bit 0 clear has no effect. The clear offset always reads 0.
- R4: Writing the start-value register also loads the CRC state with the written value masked to the current width.
- R5: A data write folds its 32 bits into the state, most significant bit first. For each bit, the feedback is the state's top bit XOR the data bit; the state shifts left by one within the width and is XORed with the polynomial when the feedback is 1. The new result is readable in the following cycle, and back-to-back data writes chain.
- R6: With mode bit 8 set, each input byte has its bits reversed before folding, so bit 0 of a byte enters first.
- R7: With mode bit 24 set, the four bytes of the data word are reversed in order before any per-byte bit reversal, so byte [7:0] enters first.
- R8: The result is the state masked to the width. When mode bit 16 is set, only those low width bits are reversed. The output mask, limited to the width, is then XORed in.
- R9: Width field values 1 to 32 select that CRC width. Values 0 and 33 to 63 behave as 32 while still reading back as written.
- R10: Writing a preset code 1 to 15 loads polynomial/start/output mask/width/reflection (both input and output reversal together, byte swap off) and reloads the state with the start value masked to that width: 1: 04C11DB7/FFFFFFFF/FFFFFFFF/32/on; 2: F4ACFB13/FFFFFFFF/FFFFFFFF/32/on; 3: 1021/0/0/16/on; 4: 1021/0/0/16/off; 5: 8005/FFFF/0/16/on; 6: 3D65/0/FFFF/16/on; 7: 1021/FFFF/FFFF/16/on; 8: 8005/FFFF/FFFF/16/on; 9: 8005/0/FFFF/16/on; 10: 8005/0/0/16/on; 11: 31/0/0/8/on; 12: 07/FF/0/8/on; 13: 07/0/55/8/off; 14: 07/0/0/8/off; 15: 05/1F/1F/5/on. Codes 0 and 16 to 255 are only stored, and no other setting changes.
- R11: Writes to the polynomial, output mask, mode, result or unused offsets, and writes whose address bits [1:0] are nonzero, leave the CRC state unchanged. An unaligned write also changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address within the channel window |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |

## Verification
The register that holds the CRC state has three write sources that can collide across adjacent cycles: a reload from a start-value or preset write, a fold from a data write, and a clear. The bench issues a preset write and then data writes on the very next cycles. It also issues a start-value write immediately followed by data writes. This shows whether the fold sees the freshly loaded width, polynomial and state. Each result is judged against a bitwise software model that runs from the requirement's parameters, and the result is read in the cycle directly after the last data write.

// File: rtl/crc_chan_pkg.sv
package crc_chan_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int WID_W   = 6;
    localparam int CODE_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int SEL_W   = ADDR_W - 2;
    localparam int NUM_STD = 15;

    localparam logic [SEL_W-1:0] SEL_PRESET = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CLEAR  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_POLY   = 4'd2;
    localparam logic [SEL_W-1:0] SEL_START  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_XMASK  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_MODE   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_DATA   = 4'd6;
    localparam logic [SEL_W-1:0] SEL_RESULT = 4'd7;
    localparam logic [SEL_W-1:0] SEL_NONE   = 4'd15;

    localparam int MODE_RIN_BIT  = 8;
    localparam int MODE_ROUT_BIT = 16;
    localparam int MODE_SWAP_BIT = 24;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t             poly;
        word_t             start;
        word_t             xmask;
        logic [WID_W-1:0]  width;
        logic              rev_in;
        logic              rev_out;
        logic              swap_in;
    } crc_cfg_t;

    function automatic logic [WID_W-1:0] eff_width(input logic [WID_W-1:0] w);
        return (w == '0 || w > 6'd32) ? 6'd32 : w;
    endfunction

    function automatic word_t width_mask(input logic [WID_W-1:0] w);
        logic [WID_W-1:0] sh;
        sh = 6'd32 - eff_width(w);
        return {WORD_W{1'b1}} >> sh;
    endfunction

    function automatic logic [7:0] rev_byte(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic word_t rev_low(input word_t v, input logic [WID_W-1:0] w);
        word_t r;
        logic [WID_W-1:0] sh;
        for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
        sh = 6'd32 - eff_width(w);
        return r >> sh;
    endfunction

    function automatic word_t mode_word(input crc_cfg_t c);
        word_t m;
        m = '0;
        m[WID_W-1:0]    = c.width;
        m[MODE_RIN_BIT]  = c.rev_in;
        m[MODE_ROUT_BIT] = c.rev_out;
        m[MODE_SWAP_BIT] = c.swap_in;
        return m;
    endfunction

    function automatic logic std_valid(input logic [CODE_W-1:0] code);
        return (code != '0) && (code <= 8'(NUM_STD));
    endfunction

    function automatic crc_cfg_t std_entry(input word_t p, input word_t s, input word_t x,
                                           input logic [WID_W-1:0] w, input logic refl);
        crc_cfg_t c;
        c.poly    = p;
        c.start   = s;
        c.xmask   = x;
        c.width   = w;
        c.rev_in  = refl;
        c.rev_out = refl;
        c.swap_in = 1'b0;
        return c;
    endfunction

    function automatic crc_cfg_t std_lookup(input logic [CODE_W-1:0] code);
        crc_cfg_t c;
        case (code)
            8'd1:    c = std_entry(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd32, 1'b1);
            8'd2:    c = std_entry(32'hF4ACFB13, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd32, 1'b1);
            8'd3:    c = std_entry(32'h1021, 32'h0,    32'h0,    6'd16, 1'b1);
            8'd4:    c = std_entry(32'h1021, 32'h0,    32'h0,    6'd16, 1'b0);
            8'd5:    c = std_entry(32'h8005, 32'hFFFF, 32'h0,    6'd16, 1'b1);
            8'd6:    c = std_entry(32'h3D65, 32'h0,    32'hFFFF, 6'd16, 1'b1);
            8'd7:    c = std_entry(32'h1021, 32'hFFFF, 32'hFFFF, 6'd16, 1'b1);
            8'd8:    c = std_entry(32'h8005, 32'hFFFF, 32'hFFFF, 6'd16, 1'b1);
            8'd9:    c = std_entry(32'h8005, 32'h0,    32'hFFFF, 6'd16, 1'b1);
            8'd10:   c = std_entry(32'h8005, 32'h0,    32'h0,    6'd16, 1'b1);
            8'd11:   c = std_entry(32'h31,   32'h0,    32'h0,    6'd8,  1'b1);
            8'd12:   c = std_entry(32'h07,   32'hFF,   32'h0,    6'd8,  1'b1);
            8'd13:   c = std_entry(32'h07,   32'h0,    32'h55,   6'd8,  1'b0);
            8'd14:   c = std_entry(32'h07,   32'h0,    32'h0,    6'd8,  1'b0);
            8'd15:   c = std_entry(32'h05,   32'h1F,   32'h1F,   6'd5,  1'b1);
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
    import crc_chan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     sel,
    input  word_t                wdata,
    output crc_cfg_t             cfg,
    output logic [CODE_W-1:0]    code,
    output word_t                data_q,
    output logic                 clear_hit,
    output logic                 load_hit,
    output word_t                load_val
);

    crc_cfg_t std_cfg;
    logic     std_hit;

    always_comb begin
        std_cfg   = std_lookup(wdata[CODE_W-1:0]);
        std_hit   = wr_en && (sel == SEL_PRESET) && std_valid(wdata[CODE_W-1:0]);
        clear_hit = wr_en && (sel == SEL_CLEAR) && wdata[0];
        load_hit  = std_hit || (wr_en && (sel == SEL_START));
        load_val  = std_hit ? (std_cfg.start & width_mask(std_cfg.width))
                            : (wdata & width_mask(cfg.width));
    end

    always_ff @(posedge clk) begin
        if (rst || clear_hit) begin
            cfg    <= '0;
            code   <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_PRESET: begin
                    code <= wdata[CODE_W-1:0];
                    if (std_hit) cfg <= std_cfg;
                end
                SEL_POLY:  cfg.poly  <= wdata;
                SEL_START: cfg.start <= wdata;
                SEL_XMASK: cfg.xmask <= wdata;
                SEL_MODE: begin
                    cfg.width   <= wdata[WID_W-1:0];
                    cfg.rev_in  <= wdata[MODE_RIN_BIT];
                    cfg.rev_out <= wdata[MODE_ROUT_BIT];
                    cfg.swap_in <= wdata[MODE_SWAP_BIT];
                end
                SEL_DATA:  data_q <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
    import crc_chan_pkg::*;
(
    input  word_t             state,
    input  word_t             word,
    input  word_t             poly,
    input  logic [WID_W-1:0]  width,
    input  logic              rev_in,
    input  logic              swap_in,
    output word_t             next_state
);

    word_t swapped;
    word_t bitstream;

    // byte order: reversed word when swapping, then per-byte reflection
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign swapped[8*b +: 8] = swap_in ? word[8*(BYTES-1-b) +: 8] : word[8*b +: 8];
        assign bitstream[8*b +: 8] = rev_in ? rev_byte(swapped[8*b +: 8]) : swapped[8*b +: 8];
    end

    always_comb begin
        word_t       msk;
        word_t       s;
        word_t       taps;
        logic [4:0]  top_i;
        logic        fb;
        msk   = width_mask(width);
        taps  = poly & msk;
        top_i = 5'(eff_width(width) - 6'd1);
        s     = state & msk;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = s[top_i] ^ bitstream[i];
            s  = (s << 1) & msk;
            if (fb) s = s ^ taps;
        end
        next_state = s;
    end

endmodule

// File: rtl/crc_out_shaper.sv
module crc_out_shaper
    import crc_chan_pkg::*;
(
    input  word_t             state,
    input  word_t             xmask,
    input  logic [WID_W-1:0]  width,
    input  logic              rev_out,
    output word_t             result
);

    always_comb begin
        word_t msk;
        word_t base;
        msk    = width_mask(width);
        base   = state & msk;
        result = (rev_out ? rev_low(base, width) : base) ^ (xmask & msk);
    end

endmodule

// File: rtl/crc_chan.sv
module crc_chan
    import crc_chan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [5:0]          bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata
);

    logic [SEL_W-1:0]  sel;
    crc_cfg_t          cfg;
    logic [CODE_W-1:0] code;
    word_t             data_q;
    logic              clear_hit;
    logic              load_hit;
    word_t             load_val;
    word_t             state;
    word_t             fold_next;
    word_t             result;
    logic              data_we;

    // unaligned accesses decode to an unused slot
    assign sel     = (bus_addr[1:0] == 2'b00) ? bus_addr[ADDR_W-1:2] : SEL_NONE;
    assign data_we = bus_we && (sel == SEL_DATA);

    crc_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_we),
        .sel       (sel),
        .wdata     (bus_wdata),
        .cfg       (cfg),
        .code      (code),
        .data_q    (data_q),
        .clear_hit (clear_hit),
        .load_hit  (load_hit),
        .load_val  (load_val)
    );

    crc_fold_unit u_fold (
        .state      (state),
        .word       (bus_wdata),
        .poly       (cfg.poly),
        .width      (cfg.width),
        .rev_in     (cfg.rev_in),
        .swap_in    (cfg.swap_in),
        .next_state (fold_next)
    );

    crc_out_shaper u_out (
        .state   (state),
        .xmask   (cfg.xmask),
        .width   (cfg.width),
        .rev_out (cfg.rev_out),
        .result  (result)
    );

    always_ff @(posedge clk) begin
        if (rst || clear_hit) state <= '0;
        else if (load_hit)    state <= load_val;
        else if (data_we)     state <= fold_next;
    end

    always_comb begin
        case (sel)
            SEL_PRESET: bus_rdata = {{(WORD_W-CODE_W){1'b0}}, code};
            SEL_POLY:   bus_rdata = cfg.poly;
            SEL_START:  bus_rdata = cfg.start;
            SEL_XMASK:  bus_rdata = cfg.xmask;
            SEL_MODE:   bus_rdata = mode_word(cfg);
            SEL_DATA:   bus_rdata = data_q;
            SEL_RESULT: bus_rdata = result;
            default:    bus_rdata = '0;
        endcase
    end

    // R3: a clear strobe wipes state, settings and code
    assert_clear_wipes_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_CLEAR && bus_wdata[0]) |=> (state == '0 && cfg == '0 && code == '0));

    // R4: start-value write reloads the state masked to the width in force
    assert_start_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_START) |=> (state == ($past(bus_wdata) & width_mask(cfg.width))));

    // R10: a valid preset code leaves the state at the new start value
    assert_preset_reload_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_PRESET && std_valid(bus_wdata[CODE_W-1:0]))
        |=> (state == (cfg.start & width_mask(cfg.width))));

    // R11: writes outside data/start/preset/clear keep the state
    assert_state_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (sel == SEL_POLY || sel == SEL_XMASK || sel == SEL_MODE ||
                    sel == SEL_RESULT || sel >= 4'd8 ||
                    (sel == SEL_CLEAR && !bus_wdata[0]))) |=> $stable(state));

endmodule

// File: tb/crc_chan_tb.sv
`timescale 1ns/1ps
module crc_chan_tb;

    localparam logic [5:0] A_PRESET = 6'h00, A_CLEAR = 6'h04, A_POLY = 6'h08, A_START = 6'h0C,
                           A_XMASK = 6'h10, A_MODE = 6'h14, A_DATA = 6'h18, A_RESULT = 6'h1C;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;

    always #2.5 clk = ~clk;

    crc_chan u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    typedef struct {
        logic [31:0] val;
        logic [5:0]  a;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic        mon_valid = 1'b0;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    // monitor: compares each scheduled read away from the clock edge
    always @(negedge clk) begin
        if (mon_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard empty actual=%h expected=none", rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (rdata !== e.val) begin
                    bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", e.tag, e.a, rdata, e.val);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        mon_valid = 1'b0; we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(posedge clk); #1;
        we = 1'b0; addr = a; wdata = '0;
        e.val = exp; e.a = a; e.tag = tag;
        sb.push_back(e);
        mon_valid = 1'b1;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        we = 1'b0; mon_valid = 1'b0;
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] poly, input logic [31:0] init,
                                            input logic [31:0] xo, input int w, input bit rin,
                                            input bit rout, input bit bsw, input int n,
                                            input logic [95:0] msg);
        logic [31:0] msk, s, r, wd;
        logic [7:0]  by;
        bit          inb, top;
        msk = (w >= 32) ? 32'hFFFFFFFF : ((32'h1 << w) - 32'h1);
        s = init & msk;
        for (int wi = 0; wi < n; wi++) begin
            wd = msg[95 - 32*wi -: 32];
            for (int bi = 0; bi < 4; bi++) begin
                by = bsw ? wd[8*bi +: 8] : wd[8*(3-bi) +: 8];
                for (int k = 0; k < 8; k++) begin
                    inb = rin ? by[k] : by[7-k];
                    top = s[w-1];
                    s = (s << 1) & msk;
                    if (top ^ inb) s = s ^ (poly & msk);
                end
            end
        end
        if (rout) begin
            r = '0;
            for (int i = 0; i < w; i++) r[i] = s[w-1-i];
        end else r = s;
        return r ^ (xo & msk);
    endfunction

    task automatic std_params(input int c, output logic [31:0] p, output logic [31:0] s,
                              output logic [31:0] x, output int w, output bit rf);
        case (c)
            1:  begin p = 32'h04C11DB7; s = 32'hFFFFFFFF; x = 32'hFFFFFFFF; w = 32; rf = 1; end
            2:  begin p = 32'hF4ACFB13; s = 32'hFFFFFFFF; x = 32'hFFFFFFFF; w = 32; rf = 1; end
            3:  begin p = 32'h1021; s = 32'h0;    x = 32'h0;    w = 16; rf = 1; end
            4:  begin p = 32'h1021; s = 32'h0;    x = 32'h0;    w = 16; rf = 0; end
            5:  begin p = 32'h8005; s = 32'hFFFF; x = 32'h0;    w = 16; rf = 1; end
            6:  begin p = 32'h3D65; s = 32'h0;    x = 32'hFFFF; w = 16; rf = 1; end
            7:  begin p = 32'h1021; s = 32'hFFFF; x = 32'hFFFF; w = 16; rf = 1; end
            8:  begin p = 32'h8005; s = 32'hFFFF; x = 32'hFFFF; w = 16; rf = 1; end
            9:  begin p = 32'h8005; s = 32'h0;    x = 32'hFFFF; w = 16; rf = 1; end
            10: begin p = 32'h8005; s = 32'h0;    x = 32'h0;    w = 16; rf = 1; end
            11: begin p = 32'h31;   s = 32'h0;    x = 32'h0;    w = 8;  rf = 1; end
            12: begin p = 32'h07;   s = 32'hFF;   x = 32'h0;    w = 8;  rf = 1; end
            13: begin p = 32'h07;   s = 32'h0;    x = 32'h55;   w = 8;  rf = 0; end
            14: begin p = 32'h07;   s = 32'h0;    x = 32'h0;    w = 8;  rf = 0; end
            default: begin p = 32'h05; s = 32'h1F; x = 32'h1F; w = 5; rf = 1; end
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    localparam logic [95:0] MSG = 96'h31323334_35363738_39414243;

    initial begin
        logic [31:0] p, s, x, last, m;
        int          w;
        bit          rf;
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        rd(A_PRESET, 32'h0, "R1 preset");
        rd(A_POLY,   32'h0, "R1 poly");
        rd(A_START,  32'h0, "R1 start");
        rd(A_XMASK,  32'h0, "R1 xmask");
        rd(A_MODE,   32'h0, "R1 mode");
        rd(A_DATA,   32'h0, "R1 data");
        rd(A_RESULT, 32'h0, "R1 result");

        // R2: readback of plain registers and mode layout
        wr(A_POLY, 32'hDEADBEEF); wr(A_XMASK, 32'hA5A5F00F); wr(A_MODE, 32'hFFFFFFFF);
        rd(A_POLY,  32'hDEADBEEF, "R2 poly readback");
        rd(A_XMASK, 32'hA5A5F00F, "R2 xmask readback");
        rd(A_MODE,  32'h0101013F, "R2 mode layout");
        rd(A_CLEAR, 32'h0, "R3 clear reads zero");

        // R4, R5: plain 32-bit CRC, start write then data back to back
        wr(A_MODE, 32'h00000020); wr(A_POLY, 32'h04C11DB7); wr(A_XMASK, 32'h0);
        wr(A_START, 32'hFFFFFFFF);
        wr(A_DATA, MSG[95:64]); wr(A_DATA, MSG[63:32]); wr(A_DATA, MSG[31:0]);
        rd(A_RESULT, ref_crc(32'h04C11DB7, 32'hFFFFFFFF, 0, 32, 0, 0, 0, 3, MSG), "R5 fold msb first");
        rd(A_DATA, MSG[31:0], "R2 data readback");

        // R4, R9: start value masked to width 8
        wr(A_MODE, 32'h00000008); wr(A_START, 32'h00001234);
        rd(A_RESULT, 32'h00000034, "R4 start masked to width");
        rd(A_START, 32'h00001234, "R2 start readback");

        // R10, R5, R6, R8: every standard preset, data right after the preset write
        for (int c = 1; c <= 15; c++) begin
            std_params(c, p, s, x, w, rf);
            wr(A_PRESET, 32'(c));
            wr(A_DATA, MSG[95:64]); wr(A_DATA, MSG[63:32]); wr(A_DATA, MSG[31:0]);
            rd(A_RESULT, ref_crc(p, s, x, w, rf, rf, 0, 3, MSG), $sformatf("R10 preset %0d result", c));
            rd(A_POLY,   p, $sformatf("R10 preset %0d poly", c));
            rd(A_START,  s, $sformatf("R10 preset %0d start", c));
            rd(A_XMASK,  x, $sformatf("R10 preset %0d xmask", c));
            rd(A_MODE,   32'(w) | (rf ? 32'h00010100 : 32'h0), $sformatf("R10 preset %0d mode", c));
            rd(A_PRESET, 32'(c), $sformatf("R10 preset %0d code", c));
            wr(A_PRESET, 32'(c));
            rd(A_RESULT, ref_crc(p, s, x, w, rf, rf, 0, 0, MSG), $sformatf("R10 preset %0d reload", c));
        end

        // R10: out-of-range code is stored only (settings of code 15 remain)
        wr(A_PRESET, 32'h00000020);
        rd(A_PRESET, 32'h20, "R10 invalid code stored");
        rd(A_POLY, 32'h05, "R10 invalid code keeps poly");

        // R6, R7: byte swap with input reflection only
        wr(A_POLY, 32'h04C11DB7); wr(A_XMASK, 32'h0); wr(A_MODE, 32'h01000120);
        wr(A_START, 32'h0);
        wr(A_DATA, MSG[95:64]); wr(A_DATA, MSG[63:32]);
        rd(A_RESULT, ref_crc(32'h04C11DB7, 0, 0, 32, 1, 0, 1, 2, MSG), "R7 byte swap then reflect");
        wr(A_MODE, 32'h01000020); wr(A_START, 32'h0);
        wr(A_DATA, MSG[95:64]);
        rd(A_RESULT, ref_crc(32'h04C11DB7, 0, 0, 32, 0, 0, 1, 1, MSG), "R7 byte swap alone");
        wr(A_MODE, 32'h00000120); wr(A_START, 32'h0);
        wr(A_DATA, MSG[95:64]);
        rd(A_RESULT, ref_crc(32'h04C11DB7, 0, 0, 32, 1, 0, 0, 1, MSG), "R6 bit reverse per byte");

        // R8, R9: odd widths with output reversal and mask
        wr(A_POLY, 32'h15); wr(A_XMASK, 32'hFFFFFF03); wr(A_MODE, 32'h00010105);
        wr(A_START, 32'h1F);
        wr(A_DATA, MSG[95:64]); wr(A_DATA, MSG[63:32]); wr(A_DATA, MSG[31:0]);
        rd(A_RESULT, ref_crc(32'h15, 32'h1F, 32'hFFFFFF03, 5, 1, 1, 0, 3, MSG), "R8 width 5 reversed");
        wr(A_POLY, 32'h80F); wr(A_XMASK, 32'hFFF); wr(A_MODE, 32'h0001000C);
        wr(A_START, 32'h0);
        wr(A_DATA, MSG[95:64]); wr(A_DATA, MSG[63:32]);
        rd(A_RESULT, ref_crc(32'h80F, 0, 32'hFFF, 12, 0, 1, 0, 2, MSG), "R8 width 12 out reverse only");

        // R9: width codes 0 and 40 act as 32
        wr(A_POLY, 32'h04C11DB7); wr(A_XMASK, 32'hFFFFFFFF); wr(A_MODE, 32'h00010128);
        wr(A_START, 32'hFFFFFFFF);
        wr(A_DATA, MSG[95:64]); wr(A_DATA, MSG[63:32]); wr(A_DATA, MSG[31:0]);
        rd(A_RESULT, ref_crc(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32, 1, 1, 0, 3, MSG), "R9 width 40 as 32");
        rd(A_MODE, 32'h00010128, "R9 width field raw readback");
        wr(A_MODE, 32'h00010100); wr(A_START, 32'hFFFFFFFF);
        wr(A_DATA, MSG[95:64]);
        rd(A_RESULT, ref_crc(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32, 1, 1, 0, 1, MSG), "R9 width 0 as 32");
        last = ref_crc(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32, 1, 1, 0, 1, MSG);

        // R11: non-folding writes leave the result
        wr(A_POLY, 32'h0000ABCD);
        rd(A_RESULT, last, "R11 poly write keeps state");
        wr(A_RESULT, 32'h55555555);
        rd(A_RESULT, last, "R11 result write ignored");
        wr(6'h24, 32'h12345678);
        rd(A_RESULT, last, "R11 unused offset ignored");
        wr(6'h19, 32'h99999999);
        rd(A_RESULT, last, "R11 unaligned data write ignored");
        rd(A_DATA, MSG[95:64], "R11 unaligned write changes no register");
        wr(6'h09, 32'h77777777);
        rd(A_POLY, 32'h0000ABCD, "R11 unaligned poly write ignored");
        m = 32'h00000120;
        wr(A_MODE, m);
        // output reversal off now: same state, new shaping
        rd(A_RESULT, ref_crc(32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32, 1, 0, 0, 1, MSG), "R11 mode write keeps state");

        // R3: clear with bit 0 low does nothing, bit 0 high wipes
        wr(A_CLEAR, 32'hFFFFFFFE);
        rd(A_POLY, 32'h0000ABCD, "R3 clear without bit0 ignored");
        wr(A_PRESET, 32'd3);
        wr(A_CLEAR, 32'h00000001);
        rd(A_PRESET, 32'h0, "R3 code cleared");
        rd(A_POLY,   32'h0, "R3 poly cleared");
        rd(A_START,  32'h0, "R3 start cleared");
        rd(A_XMASK,  32'h0, "R3 xmask cleared");
        rd(A_MODE,   32'h0, "R3 mode cleared");
        rd(A_DATA,   32'h0, "R3 data cleared");
        rd(A_RESULT, 32'h0, "R3 result cleared");
        idle();
        idle();
        finish_run();
    end

endmodule